// File: doc/BRIEF.md
# Bootstrap Serial Byte Receiver with Pulse-Width Auto-Detection

This block recovers 8-bit characters from a single serial data line during a boot load. It does not count processor clocks. Its bit timing comes from a one-cycle enable that fires once per period of a 32.768 kHz reference, and a phase accumulator turns that enable into 2400 bit/s sampling instants. Each character has one start bit, eight data bits sent least significant bit first, and one stop bit.

The line can carry ordinary level-coded (NRZ) data or infrared-style return-to-zero data, in which a zero is only a short low pulse at the start of its bit cell. No configuration selects between the two. A retriggerable one-shot fires on every falling edge of the line and holds the line low for a fixed number of reference ticks. A short pulse therefore reaches the deframer as a full low bit. A true NRZ low already lasts longer than the one-shot, so the one-shot does not change it.

The receiver works only while a 2-bit mode code selects asynchronous boot. In every other mode it is held idle and produces nothing.

Top module: `boot_async_rx`

## Requirements
- R1: The receiver is active only while `boot_mode` equals 2'b11. In any other mode it emits no `rx_valid` and no `rx_ferr`. A character that is partly received when the mode leaves 2'b11 is discarded, and `rx_valid` is low in the cycle after any cycle in which the mode is not 2'b11.
- R2: Bit timing comes from `ref_tick` alone. A phase accumulator adds 2400 on every tick and wraps at 32768. A start edge seen on a tick reloads it to 16384. A sample is taken on each tick where the sum reaches 32768. The accumulator always stays below 32768.
- R3: Each character is decoded as 8 data bits, least significant bit first. The byte appears on `rx_data` together with a `rx_valid` pulse that lasts exactly one clock cycle.
- R4: Level-coded (NRZ) characters at 2400 bit/s, with a low start bit and a high stop bit, are decoded correctly.
- R5: Return-to-zero characters are decoded correctly without any configuration. In this coding a zero is a low pulse of 1 to 3 reference ticks at the start of its bit cell, and a one stays high. Such characters may be freely mixed with NRZ characters.
- R6: Every falling edge of the synchronised line restarts a stretch that holds the line low for 10 reference ticks. The stretch counter never exceeds 10. NRZ data with alternating bits is still decoded without error.
- R7: A stop bit sampled low raises `rx_ferr` for exactly one cycle. No `rx_valid` is produced for that character, and `rx_data` keeps its previous value. `rx_valid` and `rx_ferr` are never high together.
- R8: A synchronous active-low reset clears `rx_data`, `rx_valid`, `rx_ferr`, the deframer state, the accumulator and the stretch counter. A character in progress at reset produces no output.
- R9: Characters sent back to back, with no idle time between the stop bit and the next start bit, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at 32.768 kHz |
| boot_mode | input | 2 | Boot mode code; 2'b11 enables the receiver |
| rxd_raw | input | 1 | Serial data line (NRZ or return-to-zero), idle high |
| rx_data | output | 8 | Last correctly framed character |
| rx_valid | output | 1 | One-cycle strobe for a new character on `rx_data` |
| rx_ferr | output | 1 | One-cycle strobe for a character with a low stop bit |

## Verification
A fault in the accumulator or in the stretch length moves the sample points, and the result shows within one character. Return-to-zero zeros are read as ones, or NRZ data is shifted, so `rx_data` differs from the byte sent at the strobe that ends that character. A wrong bit count or a wrong shift direction gives a wrong or missing strobe on the very first character. A deframer that does not return to idle swallows the next back-to-back character, so the strobe count is short by one. A faulty mode gate shows as a strobe while the mode is off.

// File: rtl/boot_rx_pkg.sv
// Package: shared types and constants for the bootstrap serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package boot_rx_pkg;
    // Mode code that enables the asynchronous boot receiver.
    localparam logic [1:0] MODE_ASYNC_BOOT = 2'b11;

    // Deframer states.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rz_stretcher.sv
// Module: rz_stretcher
// What it does: synchronises the raw serial line. On each falling edge it
// (re)starts a one-shot that forces the output low for STRETCH_TICKS
// reference ticks. The output is the AND of the synchronised line and the
// inverted one-shot, so short return-to-zero pulses look like full-width
// low bits, and long NRZ lows pass through unchanged.
// Assumes: ref_tick is a one-cycle enable that is slow compared with clk
// (at least 4 clocks between ticks), so the edge detector always loads the
// counter before the next tick.
module rz_stretcher #(
    parameter int STRETCH_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic raw_in,
    output logic line_out
);
    localparam int CW = $clog2(STRETCH_TICKS + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(STRETCH_TICKS);

    logic          sync_a;
    logic          sync_b;
    logic          sync_prev;
    logic [CW-1:0] hold_cnt;
    logic          fall_edge;

    assign fall_edge = sync_prev & ~sync_b;
    assign line_out  = sync_b & (hold_cnt == '0);

    // Purpose: two-flop synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a    <= 1'b1;
            sync_b    <= 1'b1;
            sync_prev <= 1'b1;
        end else begin
            sync_a    <= raw_in;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
        end
    end

    // Purpose: retriggerable one-shot counted in reference ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            hold_cnt <= '0;
        end else if (fall_edge) begin
            hold_cnt <= LOAD_VAL;
        end else if (tick && hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    AST_STRETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= LOAD_VAL); // R6
    AST_STRETCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_edge && enable) |=> (hold_cnt == LOAD_VAL)); // R6
endmodule

// File: rtl/bit_phase_timer.sv
// Module: bit_phase_timer
// What it does: a fractional divider that makes bit-rate sample instants
// from the reference tick. Each tick adds BAUD_HZ. A sample fires on the
// tick where the sum reaches REF_HZ, and the accumulator then wraps. A
// restart reloads half a bit, so the first sample lands near the centre of
// the start bit.
// Assumes: BAUD_HZ < REF_HZ, and restart is only asserted on a tick.
module bit_phase_timer #(
    parameter int REF_HZ  = 32768,
    parameter int BAUD_HZ = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic sample
);
    localparam int ACC_W = $clog2(REF_HZ + BAUD_HZ + 1);
    localparam logic [ACC_W-1:0] REF_V  = ACC_W'(REF_HZ);
    localparam logic [ACC_W-1:0] STEP_V = ACC_W'(BAUD_HZ);
    localparam logic [ACC_W-1:0] HALF_V = ACC_W'(REF_HZ / 2);

    logic [ACC_W-1:0] phase_acc;
    logic [ACC_W-1:0] phase_sum;

    assign phase_sum = phase_acc + STEP_V;
    assign sample    = tick & ~restart & (phase_sum >= REF_V);

    // Purpose: advance or reload the phase once per reference tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_acc <= '0;
        end else if (tick) begin
            if (restart) begin
                phase_acc <= HALF_V;
            end else if (phase_sum >= REF_V) begin
                phase_acc <= phase_sum - REF_V;
            end else begin
                phase_acc <= phase_sum;
            end
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_acc < REF_V); // R2
    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart) |=> (phase_acc == HALF_V)); // R2
endmodule

// File: rtl/async_deframer.sv
// Module: async_deframer
// What it does: start/data/stop deframer. The start edge is a high-to-low
// change seen between two reference ticks. The start bit must still read low
// at its centre sample. DATA_BITS bits follow, least significant bit first.
// A high stop bit gives a one-cycle valid strobe with the byte; a low stop
// bit gives a one-cycle framing-error strobe.
// Assumes: line is the stretched, synchronised input; sample comes from
// bit_phase_timer, which is restarted through timer_restart.
module async_deframer
    import boot_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 sample,
    output logic                 timer_restart,
    output logic [DATA_BITS-1:0] data_q,
    output logic                 valid_q,
    output logic                 ferr_q
);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

    rx_state_e            state;
    logic                 line_at_tick;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shift_q;

    assign timer_restart = enable & tick & (state == RX_IDLE) & line_at_tick & ~line;

    // Purpose: state machine, shift register and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RX_IDLE;
            line_at_tick <= 1'b1;
            bit_idx      <= '0;
            shift_q      <= '0;
            data_q       <= '0;
            valid_q      <= 1'b0;
            ferr_q       <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            if (!enable) begin
                state        <= RX_IDLE;
                line_at_tick <= 1'b1;
            end else begin
                if (tick) begin
                    line_at_tick <= line;
                end
                case (state)
                    RX_IDLE: begin
                        if (timer_restart) begin
                            state <= RX_START;
                        end
                    end
                    RX_START: begin
                        bit_idx <= '0;
                        if (sample) begin
                            state <= line ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        if (sample) begin
                            shift_q <= {line, shift_q[DATA_BITS-1:1]};
                            if (bit_idx == LAST_BIT) begin
                                state <= RX_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    RX_STOP: begin
                        if (sample) begin
                            state <= RX_IDLE;
                            if (line) begin
                                data_q  <= shift_q;
                                valid_q <= 1'b1;
                            end else begin
                                ferr_q <= 1'b1;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R3
    AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_q |=> !ferr_q); // R7
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_q && ferr_q)); // R7
    AST_DATA_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> valid_q); // R7
endmodule

// File: rtl/boot_async_rx.sv
// Module: boot_async_rx (top)
// What it does: asynchronous boot receiver. It connects the return-to-zero
// stretcher, the fractional bit timer and the deframer, and enables them
// only while the boot mode code selects asynchronous boot.
// Assumes: ref_tick is a one-cycle enable at REF_HZ derived from a slow
// reference oscillator, with clk at least 4x faster; rxd_raw idles high.
module boot_async_rx
    import boot_rx_pkg::*;
#(
    parameter int REF_HZ        = 32768,
    parameter int BAUD_HZ       = 2400,
    parameter int DATA_BITS     = 8,
    parameter int STRETCH_TICKS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_tick,
    input  logic [1:0]           boot_mode,
    input  logic                 rxd_raw,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_ferr
);
    logic rx_enable;
    logic line_clean;
    logic restart;
    logic bit_sample;

    assign rx_enable = (boot_mode == MODE_ASYNC_BOOT);

    rz_stretcher #(
        .STRETCH_TICKS(STRETCH_TICKS)
    ) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (rx_enable),
        .tick    (ref_tick),
        .raw_in  (rxd_raw),
        .line_out(line_clean)
    );

    bit_phase_timer #(
        .REF_HZ (REF_HZ),
        .BAUD_HZ(BAUD_HZ)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ref_tick),
        .restart(restart),
        .sample (bit_sample)
    );

    async_deframer #(
        .DATA_BITS(DATA_BITS)
    ) u_deframe (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (rx_enable),
        .tick         (ref_tick),
        .line         (line_clean),
        .sample       (bit_sample),
        .timer_restart(restart),
        .data_q       (rx_data),
        .valid_q      (rx_valid),
        .ferr_q       (rx_ferr)
    );

    AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode != MODE_ASYNC_BOOT) |=> !rx_valid); // R1
    AST_OFF_NO_FERR: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode != MODE_ASYNC_BOOT) |=> !rx_ferr); // R1
endmodule

// File: tb/boot_async_rx_test.sv
// Bench for boot_async_rx: fixed-seed random characters in mixed codings,
// plus directed cases for mode gating, framing errors, reset and pulse width.
module boot_async_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [1:0] boot_mode = 2'b11;
    logic       rxd_raw = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ferr;

    int n_checks = 0;
    int n_fail = 0;
    int valid_cnt = 0;
    int ferr_cnt = 0;
    int overlap_cnt = 0;
    int long_strobe_cnt = 0;
    logic [7:0] last_seen = 8'h00;
    logic       prev_valid = 1'b0;
    logic       prev_ferr = 1'b0;
    logic [2:0] tick_div = 3'd0;
    bit         done = 1'b0;

    boot_async_rx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .boot_mode(boot_mode),
        .rxd_raw  (rxd_raw),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ferr  (rx_ferr)
    );

    always #5 clk = ~clk;

    // Reference tick: one clock in every eight.
    always @(posedge clk) begin
        tick_div <= tick_div + 3'd1;
        ref_tick <= (tick_div == 3'd7);
    end

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            valid_cnt = valid_cnt + 1;
            last_seen = rx_data;
        end
        if (rx_ferr) ferr_cnt = ferr_cnt + 1;
        if (rx_valid && rx_ferr) overlap_cnt = overlap_cnt + 1;
        if ((rx_valid && prev_valid) || (rx_ferr && prev_ferr)) long_strobe_cnt = long_strobe_cnt + 1;
        prev_valid = rx_valid;
        prev_ferr = rx_ferr;
    end

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, actual, actual, expected, expected);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (ref_tick !== 1'b1);
    endtask

    task automatic idle_ticks(input int k);
        for (int i = 0; i < k; i++) begin
            wait_tick();
            #1 rxd_raw = 1'b1;
        end
    endtask

    // Bit k of a character: 0 start, 1..8 data LSB first, 9 stop.
    function automatic bit frame_bit(input logic [7:0] b, input bit stop_v, input int k);
        if (k == 0) return 1'b0;
        if (k == 9) return stop_v;
        return b[k-1];
    endfunction

    // Line level at tick offset off inside a cell for the chosen coding.
    function automatic bit line_level(input bit v, input bit rz, input int off, input int pw);
        if (v) return 1'b1;
        if (!rz) return 1'b0;
        return (off < pw) ? 1'b0 : 1'b1;
    endfunction

    // Send one character, or its first nbits cells only, at 2400 bit/s.
    task automatic send_char(input logic [7:0] b, input bit stop_v, input bit rz, input int pw, input int nbits);
        int cell_start = 0;
        int prev_k = 0;
        for (int n = 0; ; n++) begin
            int k = (n * 2400) / 32768;
            if (k >= nbits) break;
            if (k != prev_k) begin
                cell_start = n;
                prev_k = k;
            end
            wait_tick();
            #1 rxd_raw = line_level(frame_bit(b, stop_v, k), rz, n - cell_start, pw);
        end
    endtask

    // Send a full character, then check strobes and data against the model.
    task automatic send_and_check(input logic [7:0] b, input bit stop_v, input bit rz, input int pw,
                                  input int gap, input string req);
        int v0 = valid_cnt;
        int f0 = ferr_cnt;
        logic [7:0] old_data = last_seen;
        send_char(b, stop_v, rz, pw, 10);
        idle_ticks(gap);
        if (stop_v) begin
            check(valid_cnt == v0 + 1, req, valid_cnt - v0, 1);
            check(last_seen == b, req, last_seen, b);
        end else begin
            check(ferr_cnt == f0 + 1 && valid_cnt == v0, {req, " R7 ferr"}, ferr_cnt - f0, 1);
            check(rx_data == old_data, {req, " R7 data held"}, rx_data, old_data);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        int v0;
        int f0;
        seed_dummy = $urandom(32'd2400);

        // R8: reset state.
        repeat (6) @(posedge clk);
        #2;
        check(rx_valid == 1'b0 && rx_ferr == 1'b0 && rx_data == 8'h00, "R8 reset outputs", {rx_valid, rx_ferr}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        idle_ticks(4);

        // R4: NRZ basics, including alternating bits (R6) and extremes.
        send_and_check(8'hA5, 1'b1, 1'b0, 3, 3, "R4 nrz A5");
        send_and_check(8'h55, 1'b1, 1'b0, 3, 3, "R6 nrz 55 not corrupted");
        send_and_check(8'hAA, 1'b1, 1'b0, 3, 3, "R6 nrz AA not corrupted");
        send_and_check(8'h00, 1'b1, 1'b0, 3, 3, "R3 nrz 00");
        send_and_check(8'hFF, 1'b1, 1'b0, 3, 3, "R3 nrz FF");
        send_and_check(8'h01, 1'b1, 1'b0, 3, 3, "R3 lsb first 01");

        // R5: return-to-zero pulses, 3-tick and minimum 1-tick.
        send_and_check(8'h3C, 1'b1, 1'b1, 3, 3, "R5 rz 3C");
        send_and_check(8'h00, 1'b1, 1'b1, 1, 3, "R5 rz 1-tick 00");
        send_and_check(8'h80, 1'b1, 1'b1, 2, 3, "R5 rz 80");

        // R7: framing errors in both codings.
        send_and_check(8'h5A, 1'b0, 1'b0, 3, 4, "R7 nrz bad stop");
        send_and_check(8'hC3, 1'b0, 1'b1, 3, 4, "R7 rz bad stop");
        send_and_check(8'h96, 1'b1, 1'b0, 3, 3, "R7 recovers");

        // R9: back-to-back with no idle, mixed codings.
        send_and_check(8'h12, 1'b1, 1'b0, 3, 0, "R9 b2b 1");
        send_and_check(8'h34, 1'b1, 1'b1, 3, 0, "R9 b2b 2");
        send_and_check(8'h56, 1'b1, 1'b0, 3, 0, "R9 b2b 3");
        idle_ticks(3);

        // R1: other modes emit nothing; switching off mid-character discards it.
        v0 = valid_cnt;
        f0 = ferr_cnt;
        boot_mode = 2'b10;
        send_char(8'h77, 1'b1, 1'b0, 3, 10);
        send_char(8'h11, 1'b0, 1'b0, 3, 10);
        idle_ticks(4);
        check(valid_cnt == v0 && ferr_cnt == f0, "R1 mode 10 silent", valid_cnt - v0 + ferr_cnt - f0, 0);
        boot_mode = 2'b00;
        send_char(8'h21, 1'b1, 1'b1, 3, 10);
        idle_ticks(4);
        check(valid_cnt == v0 && ferr_cnt == f0, "R1 mode 00 silent", valid_cnt - v0 + ferr_cnt - f0, 0);
        boot_mode = 2'b11;
        idle_ticks(2);
        send_char(8'h0F, 1'b1, 1'b0, 3, 5);
        boot_mode = 2'b01;
        idle_ticks(30);
        boot_mode = 2'b11;
        idle_ticks(4);
        check(valid_cnt == v0 && ferr_cnt == f0, "R1 mid-char mode drop", valid_cnt - v0 + ferr_cnt - f0, 0);
        send_and_check(8'hE7, 1'b1, 1'b0, 3, 3, "R1 works after re-enable");

        // R8: reset mid-character discards it; next one is fine.
        v0 = valid_cnt;
        f0 = ferr_cnt;
        send_char(8'h00, 1'b1, 1'b0, 3, 6);
        @(posedge clk);
        #1 begin rst_n = 1'b0; rxd_raw = 1'b1; end
        repeat (20) @(posedge clk);
        #1 rst_n = 1'b1;
        idle_ticks(30);
        check(valid_cnt == v0 && ferr_cnt == f0, "R8 mid-char reset", valid_cnt - v0 + ferr_cnt - f0, 0);
        check(rx_data == 8'h00, "R8 data cleared", rx_data, 0);
        send_and_check(8'h6D, 1'b1, 1'b1, 3, 3, "R8 after reset");

        // R2/R4/R5: fixed-seed random characters, mixed coding and gaps.
        for (int i = 0; i < 40; i++) begin
            logic [7:0] b = 8'($urandom);
            bit rz = 1'($urandom);
            int pw = 1 + int'($urandom % 3);
            int gap = int'($urandom % 4);
            send_and_check(b, 1'b1, rz, pw, gap, rz ? "R5 random rz" : "R2 random nrz");
        end

        // R3/R7: strobe shape seen over the whole run.
        check(long_strobe_cnt == 0, "R3 strobes one cycle", long_strobe_cnt, 0);
        check(overlap_cnt == 0, "R7 strobes exclusive", overlap_cnt, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule